// File: doc/BRIEF.md
# Coherence Ring Memory Node

This block is the main-memory stop on a unidirectional coherence ring. It sits between the last and the first cache controller, takes ring messages into a small receive queue and sends them on through a small transmit queue. It holds a word-addressed memory array. It supplies memory data to read and write requests that no cache has answered yet. Write-back messages update the array as they pass.

The node also owns the ring's tokens. After reset it creates one token for each configured token identifier, before any other traffic leaves. A token that comes round from the last cache is sent on toward the first cache with its identifier unchanged. The node handles one message at a time, and each memory access takes one cycle. As a result, messages leave in the same order in which they arrived.

Message opcodes are read = 0, write = 1, write-back = 2 and token = 3. A token carries its identifier in the address field.

Top module: `ring_mem_node`

## Requirements
- R1: A read (opcode 0) or write (opcode 1) message that arrives with its data-valid flag at 0 leaves with the same opcode and address. Its data is replaced by the memory word at that address, and its data-valid flag is set to 1.
- R2: A read or write message that arrives with its data-valid flag at 1 leaves with every field unchanged.
- R3: A write-back message (opcode 2) stores its data at its address and leaves unchanged. Any later message that reads that address observes the stored value.
- R4: After reset the node emits NUM_TOKENS token messages (opcode 3) and nothing else comes out before them. Each has data-valid 1 and data 0, and their address fields carry the identifiers 0, 1, ... NUM_TOKENS-1 in increasing order. No output is valid while reset is asserted.
- R5: A token message that arrives on the ring leaves unchanged, so its identifier is preserved.
- R6: Messages leave in arrival order, none is lost or duplicated, and no new message is taken from the receive queue while a memory read is outstanding.
- R7: Every memory word reads as zero after reset until a write-back changes it.
- R8: While out_ready is low, out_valid and the output fields hold steady. Exactly 2*2^FIFO_LG messages are accepted before in_ready drops, and they all come out correctly once out_ready returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Incoming ring message present |
| in_ready | output | 1 | Receive queue can take a message |
| in_op | input | 2 | Incoming opcode |
| in_dv | input | 1 | Incoming data-valid flag |
| in_addr | input | ADDR_W | Incoming address or token identifier |
| in_data | input | DATA_W | Incoming data word |
| out_valid | output | 1 | Outgoing ring message present |
| out_ready | input | 1 | Next ring member takes the message |
| out_op | output | 2 | Outgoing opcode |
| out_dv | output | 1 | Outgoing data-valid flag |
| out_addr | output | ADDR_W | Outgoing address or token identifier |
| out_data | output | DATA_W | Outgoing data word |

## Verification
The bench builds the node with three tokens and queues four entries deep. Three tokens make the increasing-identifier order of the start-up burst visible beyond a single pair. The shallow queues let a short stall fill both queues, so the exact acceptance limit of eight messages can be checked and then drained in order. A mixed run over eight addresses places write-backs and fills close together, so ordering between a memory write and the read that follows it is exercised.

// File: rtl/rmn_pkg.sv
package rmn_pkg;

    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_WBACK = 2'd2,
        OP_TOKEN = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_BOOT = 2'd0,
        ST_RUN  = 2'd1,
        ST_FILL = 2'd2
    } node_st_e;

    typedef struct packed {
        op_e               op;
        logic              dv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } msg_t;

    localparam int MSG_W = $bits(msg_t);

    function automatic logic needs_fill(msg_t m);
        return ((m.op == OP_READ) || (m.op == OP_WRITE)) && !m.dv;
    endfunction

    function automatic msg_t make_token(logic [ADDR_W-1:0] id);
        msg_t t;
        t.op   = OP_TOKEN;
        t.dv   = 1'b1;
        t.addr = id;
        t.data = '0;
        return t;
    endfunction

endpackage

// File: rtl/rmn_fifo.sv
module rmn_fifo #(
    parameter int W  = 8,
    parameter int LG = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int DEPTH = 1 << LG;

    logic [W-1:0] slots [DEPTH];
    logic [LG:0]  wptr_q, rptr_q;

    assign empty = (wptr_q == rptr_q);
    assign full  = (wptr_q[LG] != rptr_q[LG]) && (wptr_q[LG-1:0] == rptr_q[LG-1:0]);
    assign dout  = slots[rptr_q[LG-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push) begin
                slots[wptr_q[LG-1:0]] <= din;
                wptr_q <= wptr_q + 1'b1;
            end
            if (pop) begin
                rptr_q <= rptr_q + 1'b1;
            end
        end
    end

    AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R8
    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R6

endmodule

// File: rtl/rmn_mem.sv
module rmn_mem #(
    parameter int AW = 6,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int WORDS = 1 << AW;

    logic [DW-1:0] words [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                words[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (wr_en) begin
                words[addr] <= wdata;
            end
            if (rd_en) begin
                rdata <= words[addr];
            end
        end
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst) !(rd_en && wr_en)); // R6

endmodule

// File: rtl/ring_mem_node.sv
module ring_mem_node
    import rmn_pkg::*;
#(
    parameter int NUM_TOKENS = 2,
    parameter int FIFO_LG    = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_op,
    input  logic              in_dv,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [1:0]        out_op,
    output logic              out_dv,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data
);
    localparam int TOK_W = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1;
    localparam logic [TOK_W-1:0] TOK_LAST = TOK_W'(NUM_TOKENS - 1);

    msg_t in_msg, head, out_msg, push_msg, hold_q, hold_d;
    logic [MSG_W-1:0] ififo_dout, ofifo_dout;
    logic ififo_full, ififo_empty, ififo_pop;
    logic ofifo_full, ofifo_empty, ofifo_push, ofifo_pop;
    logic mem_rd, mem_wr;
    logic [DATA_W-1:0] mem_rdata;
    node_st_e state_q, state_d;
    logic [TOK_W-1:0] tok_q, tok_d;

    // receive side
    always_comb begin
        in_msg.op   = op_e'(in_op);
        in_msg.dv   = in_dv;
        in_msg.addr = in_addr;
        in_msg.data = in_data;
    end

    assign in_ready = !ififo_full;
    assign head     = msg_t'(ififo_dout);

    rmn_fifo #(.W(MSG_W), .LG(FIFO_LG)) rx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (in_valid && !ififo_full),
        .din   (in_msg),
        .full  (ififo_full),
        .pop   (ififo_pop),
        .dout  (ififo_dout),
        .empty (ififo_empty)
    );

    rmn_mem #(.AW(ADDR_W), .DW(DATA_W)) store (
        .clk   (clk),
        .rst   (rst),
        .rd_en (mem_rd),
        .wr_en (mem_wr),
        .addr  (head.addr),
        .wdata (head.data),
        .rdata (mem_rdata)
    );

    // node control
    always_comb begin
        state_d    = state_q;
        tok_d      = tok_q;
        hold_d     = hold_q;
        ififo_pop  = 1'b0;
        ofifo_push = 1'b0;
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        push_msg   = head;
        unique case (state_q)
            ST_BOOT: begin
                if (!ofifo_full) begin
                    ofifo_push = 1'b1;
                    push_msg   = make_token(ADDR_W'(tok_q));
                    if (tok_q == TOK_LAST) begin
                        state_d = ST_RUN;
                    end else begin
                        tok_d = tok_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                if (!ififo_empty && !ofifo_full) begin
                    ififo_pop = 1'b1;
                    if (needs_fill(head)) begin
                        mem_rd  = 1'b1;
                        hold_d  = head;
                        state_d = ST_FILL;
                    end else begin
                        ofifo_push = 1'b1;
                        mem_wr     = (head.op == OP_WBACK);
                    end
                end
            end
            ST_FILL: begin
                ofifo_push    = 1'b1;
                push_msg      = hold_q;
                push_msg.data = mem_rdata;
                push_msg.dv   = 1'b1;
                state_d       = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_BOOT;
            tok_q   <= '0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            tok_q   <= tok_d;
            hold_q  <= hold_d;
        end
    end

    // transmit side
    rmn_fifo #(.W(MSG_W), .LG(FIFO_LG)) tx_q (
        .clk   (clk),
        .rst   (rst),
        .push  (ofifo_push),
        .din   (push_msg),
        .full  (ofifo_full),
        .pop   (ofifo_pop),
        .dout  (ofifo_dout),
        .empty (ofifo_empty)
    );

    assign out_msg   = msg_t'(ofifo_dout);
    assign out_valid = !ofifo_empty;
    assign ofifo_pop = out_valid && out_ready;
    assign out_op    = out_msg.op;
    assign out_dv    = out_msg.dv;
    assign out_addr  = out_msg.addr;
    assign out_data  = out_msg.data;

    AST_RW_LEAVES_FILLED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && (out_msg.op == OP_READ || out_msg.op == OP_WRITE)) |-> out_dv); // R1
    AST_BOOT_HOLDS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_BOOT) |-> !ififo_pop); // R4
    AST_FILL_STALLS_INPUT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |-> !ififo_pop); // R6
    AST_FILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |=> (state_q == ST_RUN)); // R6
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_addr))); // R8

endmodule

// File: tb/ring_mem_node_tb.sv
module ring_mem_node_tb_top;
    import rmn_pkg::*;

    localparam int NT = 3;
    localparam int FL = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [1:0] in_op = '0;
    logic in_dv = 1'b0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic out_valid;
    logic out_ready = 1'b1;
    logic [1:0] out_op;
    logic out_dv;
    logic [ADDR_W-1:0] out_addr;
    logic [DATA_W-1:0] out_data;

    always #10 clk = ~clk;

    ring_mem_node #(.NUM_TOKENS(NT), .FIFO_LG(FL)) dut_i (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op), .in_dv(in_dv),
        .in_addr(in_addr), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op), .out_dv(out_dv),
        .out_addr(out_addr), .out_data(out_data)
    );

    int checks = 0;
    int fails  = 0;
    msg_t  expq[$];
    string reqq[$];
    logic [DATA_W-1:0] model [1 << ADDR_W];

    function automatic msg_t mk(op_e op, logic dv, int addr, logic [DATA_W-1:0] data);
        msg_t m;
        m.op = op; m.dv = dv; m.addr = ADDR_W'(addr); m.data = data;
        return m;
    endfunction

    function automatic void expect_out(msg_t m, string r);
        msg_t e;
        e = m;
        if ((m.op == OP_READ || m.op == OP_WRITE) && !m.dv) begin
            e.data = model[m.addr];
            e.dv   = 1'b1;
        end else if (m.op == OP_WBACK) begin
            model[m.addr] = m.data;
        end
        expq.push_back(e);
        reqq.push_back(r);
    endfunction

    task automatic check(bit ok, string r, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", r, what, act, exp);
        end
    endtask

    // output scoreboard
    always @(negedge clk) begin
        msg_t got, e;
        string r;
        if (!rst && out_valid && out_ready) begin
            got.op = op_e'(out_op); got.dv = out_dv; got.addr = out_addr; got.data = out_data;
            if (expq.size() == 0) begin
                check(1'b0, "R6", "unexpected output", longint'(got), 0);
            end else begin
                e = expq.pop_front();
                r = reqq.pop_front();
                checks++;
                if (got !== e) begin
                    fails++;
                    $display("FAIL %s: got op=%0d dv=%0d addr=%0h data=%0h expected op=%0d dv=%0d addr=%0h data=%0h",
                             r, got.op, got.dv, got.addr, got.data, e.op, e.dv, e.addr, e.data);
                end
            end
        end
    end

    task automatic send(msg_t m, string r);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_op = m.op; in_dv = m.dv; in_addr = m.addr; in_data = m.data;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        expect_out(m, r);
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain(string r);
        int n;
        n = 0;
        while (expq.size() != 0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(expq.size() == 0, r, "messages left undelivered", expq.size(), 0);
    endtask

    task automatic t_reset_boot();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R4", "out_valid during reset", out_valid, 0);
        for (int i = 0; i < NT; i++) begin
            expq.push_back(make_token(ADDR_W'(i)));
            reqq.push_back("R4");
        end
        @(posedge clk); #1;
        rst = 1'b0;
        drain("R4");
    endtask

    task automatic t_fill_after_reset();
        send(mk(OP_READ, 1'b0, 9, 32'hDEAD_BEEF), "R7");
        send(mk(OP_WRITE, 1'b0, 12, 32'h1234_5678), "R7");
        drain("R7");
    endtask

    task automatic t_writeback_then_fill();
        send(mk(OP_WBACK, 1'b1, 5, 32'hA5A5_0001), "R3");
        send(mk(OP_READ, 1'b0, 5, 32'h0), "R3");
        send(mk(OP_WBACK, 1'b1, 5, 32'hA5A5_0002), "R3");
        send(mk(OP_WRITE, 1'b0, 5, 32'hFFFF_FFFF), "R1");
        drain("R3");
    endtask

    task automatic t_passthrough();
        send(mk(OP_READ, 1'b1, 5, 32'hCAFE_0001), "R2");
        send(mk(OP_WRITE, 1'b1, 5, 32'hCAFE_0002), "R2");
        send(mk(OP_READ, 1'b0, 5, 32'h0), "R2");
        drain("R2");
    endtask

    task automatic t_token_wrap();
        send(mk(OP_TOKEN, 1'b1, 2, 32'h0), "R5");
        send(mk(OP_TOKEN, 1'b1, 0, 32'h0), "R5");
        drain("R5");
    endtask

    task automatic t_backpressure();
        int acc;
        logic [DATA_W-1:0] held;
        msg_t m;
        acc = 0;
        @(posedge clk); #1;
        out_ready = 1'b0;
        for (int cyc = 0; cyc < 20; cyc++) begin
            m = mk(OP_WBACK, 1'b1, 16 + acc, 32'hB000_0000 + acc);
            in_valid = 1'b1;
            in_op = m.op; in_dv = m.dv; in_addr = m.addr; in_data = m.data;
            @(negedge clk);
            if (in_ready) begin
                expect_out(m, "R8");
                acc++;
            end
            @(posedge clk); #1;
        end
        in_valid = 1'b0;
        @(negedge clk);
        check(acc == 2 * (1 << FL), "R8", "messages accepted under stall", acc, 2 * (1 << FL));
        check(in_ready == 1'b0, "R8", "in_ready under stall", in_ready, 0);
        held = out_data;
        repeat (3) @(negedge clk);
        check(out_valid && out_data == held, "R8", "held output data", out_data, held);
        @(posedge clk); #1;
        out_ready = 1'b1;
        drain("R8");
        send(mk(OP_READ, 1'b0, 19, 32'h0), "R8");
        drain("R8");
    endtask

    task automatic t_mixed_order();
        msg_t m;
        for (int i = 0; i < 30; i++) begin
            m = mk(op_e'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                   $urandom_range(0, 7), $urandom());
            if (m.op == OP_WBACK || m.op == OP_TOKEN) m.dv = 1'b1;
            send(m, "R6");
        end
        drain("R6");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R6 watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) model[i] = '0;
        t_reset_boot();
        t_fill_after_reset();
        t_writeback_then_fill();
        t_passthrough();
        t_token_wrap();
        t_backpressure();
        t_mixed_order();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule